// File: doc/BRIEF.md
# Flag-Generating Arithmetic Logic Unit

This block is a small registered arithmetic and logic unit meant to sit next to a storage controller's datapath, where it handles address stepping, counter updates and simple masking. Two operands and a 3-bit operation code enter on one cycle. The block then registers an 8-bit result together with a five-bit status word. The status word reports carry (or borrow), sign, nibble carry (or borrow), even parity and zero.

One adder serves all four arithmetic operations: add, subtract, increment and decrement. Before the addition, the second operand is replaced by its complement, by zero or by all ones, and the carry-in is set to match. A separate bitwise unit covers AND, OR, XOR and pass-through of operand A. The result and status registers load only while the load enable is high. A synchronous reset clears both.

Top module: `alu8_flags`

## Requirements
- R1: Operation code 3'b000 adds: the result is (A + B) mod 256 and the carry flag is the carry out of bit 7.
- R2: Operation code 3'b001 subtracts: the result is (A - B) mod 256 and the carry flag acts as a borrow, set exactly when A < B as unsigned numbers.
- R3: Operation code 3'b010 increments A (B is ignored): the result is (A + 1) mod 256 and carry is set only when A is 8'hFF.
- R4: Operation code 3'b011 decrements A (B is ignored): the result is (A - 1) mod 256 and carry, acting as a borrow, is set only when A is 8'h00.
- R5: Operation codes 3'b100, 3'b101, 3'b110 and 3'b111 give A AND B, A OR B, A XOR B and A respectively, with the carry and nibble-carry flags both cleared.
- R6: The nibble-carry flag is the carry from bit 3 into bit 4 for add and increment. For subtract and decrement it is the borrow out of the low nibble.
- R7: The status word is packed as flags[4] carry, flags[3] sign, flags[2] nibble carry, flags[1] parity, flags[0] zero. The sign flag equals bit 7 of the result.
- R8: The parity flag is 1 when the result holds an even number of ones and 0 when it holds an odd number.
- R9: The zero flag is 1 exactly when the loaded result is 8'h00.
- R10: The result and flags update on the rising clock edge at which load_en is high, so they are visible one cycle after the inputs. While load_en is low, both hold their values whatever the other inputs do.
- R11: The reset is synchronous and active high. It clears the result and all flags to zero at the next rising edge, even when load_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Load result and flags at this edge |
| op_sel | input | 3 | Operation code |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| result | output | 8 | Registered result |
| flags | output | 5 | Registered status: carry, sign, nibble carry, parity, zero |

## Verification
Every result and flag is due one rising edge after the edge that samples the operands with load_en high, because there is exactly one register stage between the inputs and the outputs. The bench changes inputs on the falling edge and reads the outputs on the following falling edge, which falls half a cycle after that single rising edge. Hold behaviour is checked by driving new operands with load_en low and reading the unchanged outputs one falling edge later. Reset is checked the same way, one edge after it is asserted with load_en high.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD   = 3'b000,
        OP_SUB   = 3'b001,
        OP_INC   = 3'b010,
        OP_DEC   = 3'b011,
        OP_AND   = 3'b100,
        OP_OR    = 3'b101,
        OP_XOR   = 3'b110,
        OP_PASSA = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic sgn;
        logic aux;
        logic par;
        logic zf;
    } alu_flags_t;

    localparam int FLAG_W = 5;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int W       = 8,
    parameter int AUX_BIT = 4
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   sum,
    output logic           cy,
    output logic           aux
);
    logic [W-1:0]       b_eff;
    logic               cin;
    logic               inv;
    logic [W:0]         full;
    logic [AUX_BIT:0]   low;

    // one adder; operand B is reshaped per operation
    always_comb begin
        unique case (op)
            OP_ADD: begin b_eff = b;         cin = 1'b0; inv = 1'b0; end
            OP_SUB: begin b_eff = ~b;        cin = 1'b1; inv = 1'b1; end
            OP_INC: begin b_eff = '0;        cin = 1'b1; inv = 1'b0; end
            OP_DEC: begin b_eff = '1;        cin = 1'b0; inv = 1'b1; end
            default: begin b_eff = b;        cin = 1'b0; inv = 1'b0; end
        endcase
    end

    always_comb begin
        full = {1'b0, a} + {1'b0, b_eff} + (W+1)'(cin);
        low  = {1'b0, a[AUX_BIT-1:0]} + {1'b0, b_eff[AUX_BIT-1:0]} + (AUX_BIT+1)'(cin);
    end

    // a borrow is the complement of the adder carry
    assign sum = full[W-1:0];
    assign cy  = full[W] ^ inv;
    assign aux = low[AUX_BIT] ^ inv;

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    always_comb begin
        unique case (op)
            OP_AND:   y = a & b;
            OP_OR:    y = a | b;
            OP_XOR:   y = a ^ b;
            OP_PASSA: y = a;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/alu8_flaggen.sv
module alu8_flaggen #(
    parameter int W = 8
) (
    input  logic [W-1:0] y,
    output logic         sgn,
    output logic         par,
    output logic         zf
);
    assign sgn = y[W-1];
    assign par = ~(^y);
    assign zf  = (y == '0);

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
    import alu8_pkg::*;
#(
    parameter int W       = 8,
    parameter int AUX_BIT = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_en,
    input  logic [2:0]           op_sel,
    input  logic [W-1:0]         opnd_a,
    input  logic [W-1:0]         opnd_b,
    output logic [W-1:0]         result,
    output logic [FLAG_W-1:0]    flags
);
    alu_op_e      op;
    logic [W-1:0] arith_y;
    logic [W-1:0] logic_y;
    logic         arith_cy;
    logic         arith_aux;
    logic [W-1:0] next_y;
    logic         is_logic;
    alu_flags_t   next_f;
    logic         f_sgn, f_par, f_zf;
    logic [W-1:0] y_q;
    alu_flags_t   f_q;

    assign op       = alu_op_e'(op_sel);
    assign is_logic = op_sel[2];

    alu8_addsub #(.W(W), .AUX_BIT(AUX_BIT)) u_addsub (
        .op  (op),
        .a   (opnd_a),
        .b   (opnd_b),
        .sum (arith_y),
        .cy  (arith_cy),
        .aux (arith_aux)
    );

    alu8_logic #(.W(W)) u_logic (
        .op (op),
        .a  (opnd_a),
        .b  (opnd_b),
        .y  (logic_y)
    );

    assign next_y = is_logic ? logic_y : arith_y;

    alu8_flaggen #(.W(W)) u_flaggen (
        .y   (next_y),
        .sgn (f_sgn),
        .par (f_par),
        .zf  (f_zf)
    );

    always_comb begin
        next_f.cy  = is_logic ? 1'b0 : arith_cy;
        next_f.aux = is_logic ? 1'b0 : arith_aux;
        next_f.sgn = f_sgn;
        next_f.par = f_par;
        next_f.zf  = f_zf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q <= '0;
            f_q <= '0;
        end else if (load_en) begin
            y_q <= next_y;
            f_q <= next_f;
        end
    end

    assign result = y_q;
    assign flags  = f_q;

endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_en,
    input logic [2:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic [4:0]   flags
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result == '0 && flags == '0)); // R11

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> ($stable(result) && $stable(flags))); // R10

    AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
        (load_en && op_sel == 3'b000) |=>
        ({flags[4], result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}))); // R1

    AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
        (load_en && op_sel == 3'b001) |=>
        (result == W'($past(opnd_a) - $past(opnd_b)) &&
         flags[4] == ($past(opnd_a) < $past(opnd_b)))); // R2

    AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
        (load_en && op_sel[2]) |=> (!flags[4] && !flags[2])); // R5

    AST_SIGN_BIT: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (flags[3] == result[W-1])); // R7

    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (flags[1] == ($countones(result) % 2 == 0))); // R8

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (flags[0] == (result == '0))); // R9

endmodule

bind alu8_flags alu8_flags_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .op_sel  (op_sel),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (result),
    .flags   (flags)
);

// File: tb/alu8_flags_test.sv
module alu8_flags_test;

    localparam time CLK_HALF = 10ns;
    localparam int  NV       = 19;

    // {op, a, b, expected result, expected flags {cy,sgn,aux,par,zf}}
    localparam logic [31:0] VEC [NV] = '{
        {3'b000, 8'h3A, 8'h28, 8'h62, 5'b00100},   // R1 R6 nibble carry
        {3'b000, 8'hFF, 8'h01, 8'h00, 5'b10111},   // R1 wrap
        {3'b000, 8'h80, 8'h80, 8'h00, 5'b10011},   // R1 carry, no aux
        {3'b001, 8'h50, 8'h20, 8'h30, 5'b00010},   // R2
        {3'b001, 8'h10, 8'h01, 8'h0F, 5'b00110},   // R2 R6 nibble borrow
        {3'b001, 8'h05, 8'h07, 8'hFE, 5'b11100},   // R2 borrow
        {3'b001, 8'h42, 8'h42, 8'h00, 5'b00011},   // R2 R9
        {3'b010, 8'h0F, 8'hAA, 8'h10, 5'b00100},   // R3 R6
        {3'b010, 8'hFF, 8'h55, 8'h00, 5'b10111},   // R3 wrap
        {3'b010, 8'h7F, 8'h00, 8'h80, 5'b01100},   // R3 R7
        {3'b011, 8'h00, 8'h33, 8'hFF, 5'b11110},   // R4 borrow
        {3'b011, 8'h10, 8'hFF, 8'h0F, 5'b00110},   // R4 R6
        {3'b011, 8'h81, 8'h00, 8'h80, 5'b01000},   // R4
        {3'b100, 8'hF0, 8'h3C, 8'h30, 5'b00010},   // R5 AND
        {3'b100, 8'h0F, 8'hF0, 8'h00, 5'b00011},   // R5 R9
        {3'b101, 8'h81, 8'h42, 8'hC3, 5'b01010},   // R5 OR R8
        {3'b110, 8'hA5, 8'h01, 8'hA4, 5'b01000},   // R5 XOR R8
        {3'b111, 8'h07, 8'hFF, 8'h07, 5'b00000},   // R5 pass
        {3'b111, 8'h00, 8'hFF, 8'h00, 5'b00011}    // R5 pass zero
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load_en = 1'b0;
    logic [2:0] op_sel = 3'b000;
    logic [7:0] opnd_a = 8'h00;
    logic [7:0] opnd_b = 8'h00;
    logic [7:0] result;
    logic [4:0] flags;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    alu8_flags uut (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .op_sel  (op_sel),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .result  (result),
        .flags   (flags)
    );

    task automatic check(input string req, input logic [7:0] er, input logic [4:0] ef);
        total++;
        if (result !== er || flags !== ef) begin
            bad++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                     req, result, flags, er, ef);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [7:0] a,
                         input logic [7:0] b, input logic ld);
        @(negedge clk);
        op_sel  = op;
        opnd_a  = a;
        opnd_b  = b;
        load_en = ld;
        @(negedge clk);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R11 reset state", 8'h00, 5'b00000);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][31:29], VEC[i][28:21], VEC[i][20:13], 1'b1);
            check($sformatf("R1-R9 vector %0d op=%b", i, VEC[i][31:29]),
                  VEC[i][12:5], VEC[i][4:0]);
        end

        // R10: hold while load_en low
        drive(3'b000, 8'h3A, 8'h28, 1'b1);
        drive(3'b001, 8'h05, 8'h07, 1'b0);
        check("R10 hold with load_en low", 8'h62, 5'b00100);
        drive(3'b010, 8'hFF, 8'h00, 1'b0);
        check("R10 hold second cycle", 8'h62, 5'b00100);

        // R11: reset wins over load_en
        @(negedge clk);
        rst = 1'b1; op_sel = 3'b011; opnd_a = 8'h00; load_en = 1'b1;
        @(negedge clk);
        check("R11 reset with load_en high", 8'h00, 5'b00000);
        rst = 1'b0;

        // R3 and R4 ignore operand B
        drive(3'b010, 8'h41, 8'hFF, 1'b1);
        check("R3 B ignored", 8'h42, 5'b00010);
        drive(3'b011, 8'h41, 8'h77, 1'b1);
        check("R4 B ignored", 8'h40, 5'b00000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule